// File: doc/BRIEF.md
# Controlled Clock Gating Controller

This block turns a free-running uncontrolled clock into a controlled clock for a device under test, expressed as a one-cycle clock-enable strobe that always lines up with an edge of the uncontrolled clock. A transactor running on the uncontrolled clock can freeze the device under test at any time by dropping its ready input: no strobe is issued while ready is low, yet the transactor and every register of this block keep running.

Parameters choose how many ready uncontrolled cycles make one controlled cycle (the ratio), how many of those cycles the controlled clock level spends high (the duty), how many uncontrolled cycles after reset release pass before the first strobe (the phase), and for how many controlled cycles the device reset stays asserted. With all defaults the controlled clock runs at one strobe per ready cycle. A wrapping counter reports how many controlled cycles have been issued since reset.

The asynchronous active-low reset is applied at once and released through a short synchronizer, so all internal state leaves reset on a clean uncontrolled clock edge.

Top module: `cclk_gate_ctrl`

## Requirements
- R1: With default parameters (ratio 1, phase 0), once the internal reset is released cke_o is high in exactly those uncontrolled cycles in which ready_i is high.
- R2: In any cycle with ready_i low, cke_o is low and cyc_count_o and dut_rst_o keep their values across the following clock edge.
- R3: With ratio N, a position counter advances from 0 to N-1 and wraps on every uncontrolled edge where the block is running and ready_i is high; cke_o is high exactly when running, ready_i is high and the position is N-1. The position is held while ready_i is low.
- R4: After the internal reset is released, cke_o stays low for the first PHASE uncontrolled cycles regardless of ready_i; from then on the block is running until the next reset.
- R5: dut_rst_o is high from reset until RST_CYC strobes of cke_o have been counted, then low until the next reset; cycles with ready_i low add no strobes and so lengthen the device reset.
- R6: cyc_count_o is zero after reset and increases by one, modulo 2^CNT_W, on every uncontrolled edge at which cke_o is high.
- R7: cclk_o is high while running and the position counter is below HIGH_CYC, low otherwise, so it holds its level while frozen and is low before running.
- R8: While rst_n is low, without waiting for a clock edge, cke_o and cclk_o are low, dut_rst_o is high and cyc_count_o is zero.
- R9: The internal reset is released on the SYNC_STAGES-th rising edge of clk_u at which rst_n is high (2 by default); no strobe is issued before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_u | input | 1 | Free-running uncontrolled clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Transactor ready; low freezes the controlled clock |
| cke_o | output | 1 | Controlled clock-enable strobe, one uncontrolled cycle wide |
| cclk_o | output | 1 | Controlled clock level shaped by the duty parameter |
| dut_rst_o | output | 1 | Active-high reset for the device under test |
| cyc_count_o | output | CNT_W | Number of controlled cycles issued, wrapping |

## Verification
The hardest situation to reach is a freeze that falls inside the device reset pulse combined with a ratio above one, where the strobe, the reset release and the duty level all depend on how many ready cycles preceded the freeze. The bench reaches it with a directed sequence that releases reset, runs a few ready cycles, holds ready low for a long stretch and resumes, followed by random ready patterns of varying density with resets dropped in mid-run. A long all-ready stretch drives the narrow count past its wrap point, and a second instance with default parameters covers the one-to-one ratio.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // Bits needed to hold the values 0 .. n-1, never less than one.
  function automatic int unsigned width_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cg_reset_sync.sv
module cg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = 1'b1;
    end else begin : g_next
      assign d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= d;
    end
  end

  assign rst_n_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cg_phase_gate.sv
module cg_phase_gate
  import cg_pkg::*;
#(
  parameter int unsigned PHASE = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic running_o
);
  localparam int unsigned PH_W = width_for(PHASE + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(PHASE);

  logic [PH_W-1:0] wait_q, wait_d;
  logic            done;
  logic            wait_en;

  assign done    = (wait_q == PH_END);
  assign wait_en = !done;

  always_comb begin
    wait_d = wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end

  assign running_o = rst_n & done;

  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> running_o); // R4
endmodule

// File: rtl/cg_ratio_div.sv
module cg_ratio_div
  import cg_pkg::*;
#(
  parameter int unsigned RATIO    = 1,
  parameter int unsigned HIGH_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic last_o,
  output logic level_o
);
  localparam int unsigned DIV_W = width_for(RATIO);
  localparam logic [DIV_W-1:0] POS_LAST = DIV_W'(RATIO - 1);
  localparam logic [DIV_W:0]   HIGH_LIM = (DIV_W + 1)'(HIGH_CYC);

  logic [DIV_W-1:0] pos_q, pos_d;

  assign last_o = (pos_q == POS_LAST);

  always_comb begin
    if (last_o) pos_d = '0;
    else        pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (adv_i) pos_q <= pos_d;
  end

  assign level_o = ({1'b0, pos_q} < HIGH_LIM);

  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pos_q)); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST); // R3
endmodule

// File: rtl/cg_rst_stretch.sv
module cg_rst_stretch
  import cg_pkg::*;
#(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic dut_rst_o
);
  localparam int unsigned RC_W = width_for(RST_CYC + 1);
  localparam logic [RC_W-1:0] RC_END = RC_W'(RST_CYC);

  logic [RC_W-1:0] seen_q, seen_d;
  logic            done;
  logic            seen_en;

  assign done    = (seen_q == RC_END);
  assign seen_en = tick_i && !done;

  always_comb begin
    seen_d = seen_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  assign dut_rst_o = !done;

  AST_RST_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    !dut_rst_o |=> !dut_rst_o); // R5
  AST_RST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(dut_rst_o)); // R5
endmodule

// File: rtl/cg_cycle_count.sv
module cg_cycle_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_o == $past(count_o) + 1'b1)); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o)); // R2
endmodule

// File: rtl/cclk_gate_ctrl.sv
module cclk_gate_ctrl #(
  parameter int unsigned RATIO       = 1,
  parameter int unsigned HIGH_CYC    = 1,
  parameter int unsigned PHASE       = 0,
  parameter int unsigned RST_CYC     = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_u,
  input  logic             rst_n,
  input  logic             ready_i,
  output logic             cke_o,
  output logic             cclk_o,
  output logic             dut_rst_o,
  output logic [CNT_W-1:0] cyc_count_o
);
  logic rst_n_s;
  logic running;
  logic advance;
  logic pos_last;
  logic pos_level;

  cg_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_u),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cg_phase_gate #(.PHASE(PHASE)) u_phase (
    .clk       (clk_u),
    .rst_n     (rst_n_s),
    .running_o (running)
  );

  assign advance = running && ready_i;

  cg_ratio_div #(.RATIO(RATIO), .HIGH_CYC(HIGH_CYC)) u_div (
    .clk     (clk_u),
    .rst_n   (rst_n_s),
    .adv_i   (advance),
    .last_o  (pos_last),
    .level_o (pos_level)
  );

  assign cke_o  = advance && pos_last;
  assign cclk_o = running && pos_level;

  cg_rst_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk       (clk_u),
    .rst_n     (rst_n_s),
    .tick_i    (cke_o),
    .dut_rst_o (dut_rst_o)
  );

  cg_cycle_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk_u),
    .rst_n   (rst_n_s),
    .tick_i  (cke_o),
    .count_o (cyc_count_o)
  );

  AST_FREEZE_NO_STROBE: assert property (@(posedge clk_u) disable iff (!rst_n_s)
    !ready_i |-> !cke_o); // R2
  AST_WAIT_NO_STROBE: assert property (@(posedge clk_u) disable iff (!rst_n_s)
    !running |-> (!cke_o && !cclk_o)); // R4
  AST_COUNT_IN_RESET: assert property (@(posedge clk_u) disable iff (!rst_n_s)
    $rose(running) |-> (cyc_count_o == '0)); // R6
endmodule

// File: tb/cclk_gate_ctrl_bench.sv
module cclk_gate_ctrl_bench;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ready;
  logic       cke0, cclk0, drst0;
  logic [7:0] cnt0;
  logic       cke1, cclk1, drst1;
  logic [15:0] cnt1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cclk_gate_ctrl #(.RATIO(3), .HIGH_CYC(2), .PHASE(2), .RST_CYC(5), .CNT_W(8))
    u_cclk_gate_ctrl (
      .clk_u(clk), .rst_n(rst_n), .ready_i(ready),
      .cke_o(cke0), .cclk_o(cclk0), .dut_rst_o(drst0), .cyc_count_o(cnt0));

  cclk_gate_ctrl u_dflt (
      .clk_u(clk), .rst_n(rst_n), .ready_i(ready),
      .cke_o(cke1), .cclk_o(cclk1), .dut_rst_o(drst1), .cyc_count_o(cnt1));

  // Model state, built from the requirements.
  int rel;
  int pos [2];
  int rcnt[2];
  int ccnt[2];

  function automatic int p_ratio(int i); return (i == 0) ? 3 : 1; endfunction
  function automatic int p_high (int i); return (i == 0) ? 2 : 1; endfunction
  function automatic int p_phase(int i); return (i == 0) ? 2 : 0; endfunction
  function automatic int p_rst  (int i); return (i == 0) ? 5 : 4; endfunction
  function automatic int p_mod  (int i); return (i == 0) ? 256 : 65536; endfunction

  function automatic bit m_run(int i);
    return rst_n && (rel >= SYNC + p_phase(i));
  endfunction
  function automatic bit m_cke(int i);
    return m_run(i) && ready && (pos[i] == p_ratio(i) - 1);
  endfunction

  task automatic model_reset();
    rel = 0;
    for (int i = 0; i < 2; i++) begin
      pos[i] = 0; rcnt[i] = 0; ccnt[i] = 0;
    end
  endtask

  task automatic model_edge();
    if (!rst_n) model_reset();
    else begin
      for (int i = 0; i < 2; i++) begin
        if (m_run(i) && ready) begin
          if (pos[i] == p_ratio(i) - 1) begin
            pos[i] = 0;
            ccnt[i] = (ccnt[i] + 1) % p_mod(i);
            if (rcnt[i] < p_rst(i)) rcnt[i]++;
          end else pos[i]++;
        end
      end
      if (rel < 1000) rel++;
    end
  endtask

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    int g_cke, g_cclk, g_rst, g_cnt;
    string tag;
    for (int i = 0; i < 2; i++) begin
      g_cke  = (i == 0) ? int'(cke0)  : int'(cke1);
      g_cclk = (i == 0) ? int'(cclk0) : int'(cclk1);
      g_rst  = (i == 0) ? int'(drst0) : int'(drst1);
      g_cnt  = (i == 0) ? int'(cnt0)  : int'(cnt1);
      if (!rst_n)          tag = "R8";
      else if (rel < SYNC) tag = "R9";
      else if (!ready)     tag = "R2";
      else if (!m_run(i))  tag = "R4";
      else if (i == 1)     tag = "R1";
      else                 tag = "R3";
      chk(tag, "cke", g_cke, int'(m_cke(i)));
      chk(rst_n ? "R7" : "R8", "cclk", g_cclk, int'(m_run(i) && (pos[i] < p_high(i))));
      chk(rst_n ? "R5" : "R8", "dut_rst", g_rst, int'(rcnt[i] < p_rst(i)));
      chk(rst_n ? "R6" : "R8", "count", g_cnt, ccnt[i]);
    end
  endtask

  // One uncontrolled cycle: drive ready after the falling edge, check, then step the model.
  task automatic cycle(bit rdy);
    @(negedge clk);
    ready = rdy;
    #1;
    check_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic apply_reset(int len);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    check_all();              // R8: immediate, no clock edge yet
    @(posedge clk);
    for (int k = 0; k < len; k++) cycle($urandom_range(0, 1));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    ready = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    check_all();              // reset state, R8
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    model_edge();

    // Directed: steady ready through sync, phase and the reset pulse (R1, R4, R5, R9).
    for (int k = 0; k < 30; k++) cycle(1'b1);

    // Directed: freeze inside the device reset pulse (R2, R5, R7).
    apply_reset(3);
    for (int k = 0; k < 7; k++)  cycle(1'b1);
    for (int k = 0; k < 40; k++) cycle(1'b0);
    for (int k = 0; k < 25; k++) cycle(1'b1);

    // Directed: alternating ready against ratio 3 (R3).
    for (int k = 0; k < 40; k++) cycle(k[0]);

    // Long ready stretch: wraps the 8-bit count (R6).
    for (int k = 0; k < 900; k++) cycle(1'b1);

    // Random segments with varying ready density and occasional resets.
    for (int s = 0; s < 60; s++) begin
      int len = $urandom_range(5, 60);
      int dens = $urandom_range(0, 100);
      if (s % 13 == 7) apply_reset($urandom_range(0, 4));
      for (int k = 0; k < len; k++) cycle(($urandom % 100) < dens);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule